// File: doc/BRIEF.md
# Galois-Field Seventh-Power Substitution Box

This block is a pipelined substitution box that takes a 10-bit input and returns an 8-bit output. The two outer input bits pick one of four rows. Each row has its own 8-bit XOR offset and its own 9-bit reduction polynomial. The middle eight bits are XORed with the row offset. The result is then raised to the seventh power in GF(2^8), modulo the row polynomial.

The power is not read from a stored table. Six multiply-reduce stages compute it in Montgomery form, with R = x^8:

1. Convert into Montgomery form, using a per-row R^2 constant.
2. Square.
3. Multiply by the converted value.
4. Square.
5. Multiply by the converted value.
6. Convert back out.

The row polynomial and the converted value travel down the pipeline with the partial result. A new input can be accepted on every clock. A compile-time parameter selects which of four constant sets the instance uses, so one source serves all four boxes of a round function.

Top module: `gf7_sbox`

## Requirements
- R1: The row index is {inData[9], inData[0]}, with inData[9] as its MSB. The column is inData[8:1].
- R2: For a valid input, outData equals (column XOR offset[row])^7. The product is a carry-less product over GF(2), reduced modulo poly[row].
- R3: The row offsets for rows 0,1,2,3 are:
  - BOX_ID 1: 131,133,155,205
  - BOX_ID 2: 204,167,173,65
  - BOX_ID 3: 75,46,212,51
  - BOX_ID 4: 234,205,46,4
- R4: The row polynomials for rows 0,1,2,3 are:
  - BOX_ID 1: 333,313,505,369
  - BOX_ID 2: 379,375,319,391
  - BOX_ID 3: 361,445,451,397
  - BOX_ID 4: 397,425,395,505
- R5: outValid rises exactly 6 clock edges after an accepted input (inValid high at an edge). It is low on any cycle that has no input 6 edges earlier.
- R6: Inputs presented on consecutive clocks each produce a result, on consecutive clocks, in input order.
- R7: An input whose column equals its row offset produces outData = 0.
- R8: While outValid is low, outData keeps its previous value.
- R9: An active-low asynchronous reset forces outValid and outData to 0 and discards every input in flight.
- R10: The parameter BOX_ID (1 to 4) selects which constant set of R3 and R4 the instance uses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Input word present this cycle |
| inData | input | 10 | Input word: row bits 9 and 0, column bits 8:1 |
| outValid | output | 1 | Result present this cycle |
| outData | output | 8 | Seventh-power result |

## Verification
The hardest case to reach from the ports is one where the column equals the offset of its own row. It needs both outer bits and all eight inner bits set to one exact pattern per row and per box. A full sweep of all 1024 input words reaches it for every row of all four boxes, since one instance of each box sees the same stimulus. That sweep runs back-to-back, which also exercises full throughput. Random traffic with gaps follows, to test that the output holds while idle. Finally, a reset is applied while items are in flight, to show those items never emerge.

// File: rtl/gf7_sbox_pkg.sv
package gf7_sbox_pkg;

  localparam int GF_W        = 8;
  localparam int POLY_W      = GF_W + 1;
  localparam int IN_W        = GF_W + 2;
  localparam int ROWS        = 4;
  localparam int PIPE_STAGES = 6;

  typedef logic [GF_W-1:0]   gfElem_t;
  typedef logic [POLY_W-1:0] gfPoly_t;

  typedef struct packed {
    logic [PIPE_STAGES-1:0] stageLoad;
  } ctrlStrobes_t;

  typedef struct packed {
    gfElem_t acc;
    gfElem_t aVal;
    gfPoly_t poly;
  } stageData_t;

  function automatic gfElem_t rowOffset(input int boxId, input logic [1:0] row);
    int idx;
    idx = (boxId - 1) * ROWS + int'(row);
    case (idx)
      0:  return 8'd131;
      1:  return 8'd133;
      2:  return 8'd155;
      3:  return 8'd205;
      4:  return 8'd204;
      5:  return 8'd167;
      6:  return 8'd173;
      7:  return 8'd65;
      8:  return 8'd75;
      9:  return 8'd46;
      10: return 8'd212;
      11: return 8'd51;
      12: return 8'd234;
      13: return 8'd205;
      14: return 8'd46;
      15: return 8'd4;
      default: return '0;
    endcase
  endfunction

  function automatic gfPoly_t rowPoly(input int boxId, input logic [1:0] row);
    int idx;
    idx = (boxId - 1) * ROWS + int'(row);
    case (idx)
      0:  return 9'd333;
      1:  return 9'd313;
      2:  return 9'd505;
      3:  return 9'd369;
      4:  return 9'd379;
      5:  return 9'd375;
      6:  return 9'd319;
      7:  return 9'd391;
      8:  return 9'd361;
      9:  return 9'd445;
      10: return 9'd451;
      11: return 9'd397;
      12: return 9'd397;
      13: return 9'd425;
      14: return 9'd395;
      15: return 9'd505;
      default: return 9'd283;
    endcase
  endfunction

  // x^(2*GF_W) mod p, the constant that moves an operand into Montgomery form
  function automatic gfElem_t montR2(input gfPoly_t p);
    gfPoly_t r;
    r = gfPoly_t'(1);
    for (int i = 0; i < 2 * GF_W; i++) begin
      r = {r[GF_W-1:0], 1'b0};
      if (r[GF_W]) r = r ^ p;
    end
    return r[GF_W-1:0];
  endfunction

  // Bit-serial Montgomery product over GF(2): a*b*x^-GF_W mod p
  function automatic gfElem_t montMul(input gfElem_t a, input gfElem_t b, input gfPoly_t p);
    gfPoly_t acc;
    acc = '0;
    for (int k = 0; k < GF_W; k++) begin
      if (a[k]) acc = acc ^ {1'b0, b};
      if (acc[0]) acc = acc ^ p;
      acc = {1'b0, acc[GF_W:1]};
    end
    return acc[GF_W-1:0];
  endfunction

endpackage

// File: rtl/gf7_sbox_ctrl.sv
module gf7_sbox_ctrl
  import gf7_sbox_pkg::*;
#(
  parameter int STAGES = PIPE_STAGES
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  output ctrlStrobes_t strobes,
  output logic         outValid
);

  logic [STAGES-1:0] vldPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) vldPipe <= '0;
    else       vldPipe <= {vldPipe[STAGES-2:0], inValid};
  end

  always_comb begin
    strobes.stageLoad = {vldPipe[STAGES-2:0], inValid};
  end

  assign outValid = vldPipe[STAGES-1];

endmodule

// File: rtl/gf7_sbox_dp.sv
module gf7_sbox_dp
  import gf7_sbox_pkg::*;
#(
  parameter int BOX_ID = 1
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrlStrobes_t strobes,
  input  logic [IN_W-1:0] inData,
  output gfElem_t      outData
);

  localparam int LAST = PIPE_STAGES - 1;

  gfElem_t offTbl  [ROWS];
  gfPoly_t polyTbl [ROWS];
  gfElem_t r2Tbl   [ROWS];

  for (genvar r = 0; r < ROWS; r++) begin : gRow
    assign offTbl[r]  = rowOffset(BOX_ID, 2'(r));
    assign polyTbl[r] = rowPoly(BOX_ID, 2'(r));
    assign r2Tbl[r]   = montR2(rowPoly(BOX_ID, 2'(r)));
  end

  logic [1:0] rowSel;
  gfElem_t    colIn;
  gfElem_t    selOff;
  gfElem_t    selR2;
  gfPoly_t    selPoly;
  gfElem_t    convIn;

  assign rowSel  = {inData[IN_W-1], inData[0]};
  assign colIn   = inData[IN_W-2:1];
  assign selOff  = offTbl[rowSel];
  assign selPoly = polyTbl[rowSel];
  assign selR2   = r2Tbl[rowSel];
  assign convIn  = montMul(colIn ^ selOff, selR2, selPoly);

  stageData_t pipe [LAST];
  gfElem_t    outReg;

  // stage 0: conversion into Montgomery form
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      pipe[0] <= '0;
    else if (strobes.stageLoad[0])  pipe[0] <= '{acc: convIn, aVal: convIn, poly: selPoly};
  end

  // stages 1..LAST-1: square, times A, square, times A
  for (genvar i = 1; i < LAST; i++) begin : gStage
    localparam bit IS_SQUARE = (i % 2) == 1;
    gfElem_t opB;
    assign opB = IS_SQUARE ? pipe[i-1].acc : pipe[i-1].aVal;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pipe[i] <= '0;
      else if (strobes.stageLoad[i])
        pipe[i] <= '{acc:  montMul(pipe[i-1].acc, opB, pipe[i-1].poly),
                     aVal: pipe[i-1].aVal,
                     poly: pipe[i-1].poly};
    end
  end

  // last stage: conversion out of Montgomery form (multiply by 1)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outReg <= '0;
    else if (strobes.stageLoad[LAST])
      outReg <= montMul(pipe[LAST-1].acc, gfElem_t'(1), pipe[LAST-1].poly);
  end

  assign outData = outReg;

endmodule

// File: rtl/gf7_sbox.sv
module gf7_sbox
  import gf7_sbox_pkg::*;
#(
  parameter int BOX_ID = 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic [IN_W-1:0] inData,
  output logic            outValid,
  output logic [GF_W-1:0] outData
);

  ctrlStrobes_t strobes;

  gf7_sbox_ctrl #(.STAGES(PIPE_STAGES)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobes  (strobes),
    .outValid (outValid)
  );

  gf7_sbox_dp #(.BOX_ID(BOX_ID)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .inData  (inData),
    .outData (outData)
  );

endmodule

// File: rtl/gf7_sbox_chk.sv
module gf7_sbox_chk
  import gf7_sbox_pkg::*;
#(
  parameter int BOX_ID = 1
) (
  input logic            clk,
  input logic            rstN,
  input logic            inValid,
  input logic [IN_W-1:0] inData,
  input logic            outValid,
  input logic [GF_W-1:0] outData
);

  logic zeroHit;
  assign zeroHit = inValid &&
    (inData[IN_W-2:1] == rowOffset(BOX_ID, {inData[IN_W-1], inData[0]}));

  a_r5_latency: assert property (@(posedge clk) disable iff (!rstN)
    inValid |-> ##6 outValid);

  a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |-> ##6 !outValid);

  a_r7_zero_result: assert property (@(posedge clk) disable iff (!rstN)
    zeroHit |-> ##6 (outData == '0));

  a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable(outData));

  a_r9_reset_clear: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!outValid && outData == '0));

endmodule

bind gf7_sbox gf7_sbox_chk #(.BOX_ID(BOX_ID)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inData   (inData),
  .outValid (outValid),
  .outData  (outData)
);

// File: tb/gf7_sbox_test.sv
module gf7_sbox_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inValid = 1'b0;
  logic [9:0] inData = '0;
  logic       outV [4];
  logic [7:0] outD [4];

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  for (genvar b = 0; b < 4; b++) begin : gBox
    gf7_sbox #(.BOX_ID(b + 1)) uut (
      .clk      (clk),
      .rstN     (rstN),
      .inValid  (inValid),
      .inData   (inData),
      .outValid (outV[b]),
      .outData  (outD[b])
    );
  end

  // R3 / R4 constants, indexed box*4+row
  int offs [16] = '{131,133,155,205, 204,167,173,65, 75,46,212,51, 234,205,46,4};
  int polys[16] = '{333,313,505,369, 379,375,319,391, 361,445,451,397, 397,425,395,505};

  function automatic int gmul(int a, int b, int p);
    int r = 0;
    for (int i = 0; i < 8; i++) if (((b >> i) & 1) != 0) r = r ^ (a << i);
    for (int i = 15; i >= 8; i--) if (((r >> i) & 1) != 0) r = r ^ (p << (i - 8));
    return r;
  endfunction

  function automatic int pow7(int x, int p);
    int res = 1;
    int base = x;
    for (int e = 0; e < 3; e++) begin
      res = gmul(res, base, p);
      base = gmul(base, base, p);
    end
    return res;
  endfunction

  // R1 row/column split, R2 power, R10 box selection
  function automatic int refOut(int box, logic [9:0] d);
    int row = {30'd0, d[9], d[0]};
    int col = int'(d[8:1]);
    return pow7(col ^ offs[box*4+row], polys[box*4+row]);
  endfunction

  function automatic bit isZeroCase(int box, logic [9:0] d);
    int row = {30'd0, d[9], d[0]};
    return int'(d[8:1]) == offs[box*4+row];
  endfunction

  logic       histV [0:6];
  logic [9:0] histD [0:6];
  int         lastOut [4];

  task automatic clearHist();
    for (int i = 0; i < 7; i++) begin histV[i] = 1'b0; histD[i] = '0; end
    for (int b = 0; b < 4; b++) lastOut[b] = 0;
  endtask

  task automatic fail(string req, int b, int act, int exp);
    errors++;
    $display("FAIL %s box=%0d actual=%0d expected=%0d", req, b + 1, act, exp);
  endtask

  task automatic checkOutputs(string ctx);
    for (int b = 0; b < 4; b++) begin
      checks++;
      if (outV[b] !== histV[6]) fail({"R5 R6 valid ", ctx}, b, int'(outV[b]), int'(histV[6]));
      checks++;
      if (histV[6]) begin
        int exp = refOut(b, histD[6]);
        lastOut[b] = exp;
        if (int'(outD[b]) != exp) begin
          if (isZeroCase(b, histD[6])) fail({"R7 ", ctx}, b, int'(outD[b]), exp);
          else fail({"R2 R1 R3 R4 R10 ", ctx}, b, int'(outD[b]), exp);
        end
      end else if (int'(outD[b]) != lastOut[b]) begin
        fail({"R8 hold ", ctx}, b, int'(outD[b]), lastOut[b]);
      end
    end
  endtask

  task automatic step(logic v, logic [9:0] d, string ctx);
    @(negedge clk);
    inValid = v;
    inData  = d;
    for (int i = 6; i > 0; i--) begin histV[i] = histV[i-1]; histD[i] = histD[i-1]; end
    histV[0] = v;
    histD[0] = d;
    checkOutputs(ctx);
  endtask

  task automatic checkResetState();
    for (int b = 0; b < 4; b++) begin
      checks++;
      if (outV[b] !== 1'b0 || outD[b] !== 8'd0)
        fail("R9 reset", b, int'({outV[b], outD[b]}), 0);
    end
  endtask

  initial begin
    clearHist();
    repeat (3) @(negedge clk);
    checkResetState();
    @(negedge clk);
    rstN = 1'b1;

    // R6: exhaustive sweep, back to back; includes every R7 case
    for (int i = 0; i < 1024; i++) step(1'b1, 10'(i), "R6 sweep");
    for (int i = 0; i < 8; i++) step(1'b0, '0, "R8 drain");

    // random traffic with gaps (R8 hold while idle)
    for (int i = 0; i < 800; i++) step(1'($urandom_range(0, 2) == 0), 10'($urandom), "R8 gaps");
    for (int i = 0; i < 8; i++) step(1'b0, '0, "R8 drain");

    // R9: reset with items in flight
    for (int i = 0; i < 4; i++) step(1'b1, 10'($urandom), "R9 prefill");
    @(negedge clk);
    inValid = 1'b0;
    rstN = 1'b0;
    clearHist();
    #1;
    checkResetState();
    @(negedge clk);
    checkResetState();
    rstN = 1'b1;
    for (int i = 0; i < 10; i++) step(1'b0, '0, "R9 flushed");

    // tail burst
    for (int i = 0; i < 40; i++) step(1'b1, 10'($urandom), "R6 burst");
    for (int i = 0; i < 8; i++) step(1'b0, '0, "R8 drain");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule